// File: doc/BRIEF.md
# Cascaded Add-Compare-Select Datapath for Viterbi State Metrics

This block advances the path metrics of a 16-state group of a convolutional-code trellis by one to four trellis steps in a single pass. The 16 starting metrics are read once, carried through up to four add-compare-select (ACS) layers inside the block, and handed back once. Metric memory is therefore touched once per group of steps rather than once per step. While the metrics are being updated, each state also builds up its survivor path bits by register exchange. The result is a short per-state bit segment, one bit per processed step, that a traceback unit can use directly without resolving it further.

Inside a group, the state index is local. After each step, local state `d` is reached from local states `2d mod 16` (branch 0) and `2d mod 16 + 1` (branch 1). A code with four to eight memory elements (constraint length 5 to 9) is processed as a series of such groups. The caller supplies, for every step and every destination state, the branch metrics of both incoming branches, and it picks the group and the branch metrics to suit the code. Metrics are unsigned and treated as larger-is-better. Each pass can choose how many steps it applies. The datapath is fully pipelined and accepts a new pass every clock.

Top module: `vit_acs_cascade`

## Requirements
- R1: During synchronous reset and on the first cycle after it, `res_vld` is 0 and `res_metric` and `res_seg` are all zero.
- R2: A pass presented with `in_vld` high produces `res_vld` high exactly 5 clock edges later. Passes leave the block in the order they entered.
- R3: In each applied step, for destination `d`, the candidate for branch b is the metric of local state `(2d mod 16) + b` plus that branch's metric, taken modulo 2^MW. The larger candidate becomes the new metric of `d`.
- R4: When the two candidates are equal, branch 0 (the lower-index predecessor) is chosen.
- R5: The decision bit of a step is 1 when branch 1 was chosen. The segment of a state is the survivor's segment shifted left by one with the new decision in bit 0. After S steps, bit 0 holds the last step's decision and bit S-1 holds the first step's.
- R6: `cfg_steps` code c applies c+1 steps (code 0 gives 1 step, code 3 gives 4). Branch metrics of steps beyond that count have no effect on the results.
- R7: Segment bits at positions S and above are zero.
- R8: If the state-0 metric after the last applied step is 2^(MW-1) or more, 2^(MW-2) is subtracted from every state's metric. Otherwise the metrics are output unchanged.
- R9: Passes on consecutive cycles are processed independently, with no interaction between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Pass valid |
| cfg_steps | input | SCW (2) | Step count code: steps = code + 1 |
| in_metric | input | NST*MW (192) | Starting metrics; local state d at [d*MW +: MW] |
| in_bm | input | MAX_STG*NST*2*BW (768) | Branch metric of step k, destination d, branch b at [((k*NST+d)*2+b)*BW +: BW] |
| res_vld | output | 1 | Result valid |
| res_metric | output | NST*MW (192) | Updated metrics; state d at [d*MW +: MW] |
| res_seg | output | NST*MAX_STG (64) | Path segments; state d at [d*MAX_STG +: MAX_STG] |

## Verification
The bench drives equal-candidate ties. A compare written as greater-or-equal would choose branch 1 there and fill the segments with ones. It favours branch 1 at every step to confirm the bit order of the segment, because a reversed exchange would put the first decision in bit 0. Every step-count code is used, and the code-1 case is repeated with different late-step branch metrics, so that a stage that ignores the count, or leaks stale bits above the segment length, shows up as wrong metrics or stray high bits. Normalization is tested on both sides of the half-range threshold, where an off-by-one threshold or a wrong offset gives metrics off by a quarter of the range. Back-to-back random passes expose any mixing of data between pipeline slots.

// File: rtl/vac_pkg.sv
package vac_pkg;
   // local predecessor of destination d on branch b in a shift trellis of nst states
   function automatic int vac_pred(int d, int b, int nst);
      return ((d * 2) % nst) + b;
   endfunction
endpackage

// File: rtl/vac_stage.sv
module vac_stage #(
   parameter int MW  = 12,
   parameter int BW  = 6,
   parameter int NST = 16,
   parameter int SD  = 4,
   parameter int SCW = 2,
   parameter int IDX = 0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     v_i,
   input  logic [SCW-1:0]           code_i,
   input  logic [NST*MW-1:0]        met_i,
   input  logic [NST*SD-1:0]        seg_i,
   input  logic [SD*NST*2*BW-1:0]   bm_i,
   output logic                     v_o,
   output logic [SCW-1:0]           code_o,
   output logic [NST*MW-1:0]        met_o,
   output logic [NST*SD-1:0]        seg_o,
   output logic [SD*NST*2*BW-1:0]   bm_o
);
   localparam int BMV = SD*NST*2*BW;

   logic              active;
   logic [NST*MW-1:0] met_n;
   logic [NST*SD-1:0] seg_n;

   assign active = (int'(code_i) >= IDX);

   for (genvar d = 0; d < NST; d++) begin : g_acs
      localparam int P0 = vac_pkg::vac_pred(d, 0, NST);
      localparam int P1 = vac_pkg::vac_pred(d, 1, NST);
      logic [MW-1:0] cand0, cand1;
      logic          dec;
      assign cand0 = met_i[P0*MW +: MW]
                   + {{(MW-BW){1'b0}}, bm_i[((IDX*NST+d)*2+0)*BW +: BW]};
      assign cand1 = met_i[P1*MW +: MW]
                   + {{(MW-BW){1'b0}}, bm_i[((IDX*NST+d)*2+1)*BW +: BW]};
      assign dec   = (cand1 > cand0);
      assign met_n[d*MW +: MW] = dec ? cand1 : cand0;
      assign seg_n[d*SD +: SD] = dec ? {seg_i[P1*SD +: SD-1], 1'b1}
                                     : {seg_i[P0*SD +: SD-1], 1'b0};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_o    <= 1'b0;
         code_o <= '0;
         met_o  <= '0;
         seg_o  <= '0;
         bm_o   <= '0;
      end else begin
         v_o    <= v_i;
         code_o <= code_i;
         bm_o   <= bm_i;
         met_o  <= active ? met_n : met_i;
         seg_o  <= active ? seg_n : seg_i;
      end
   end

   if (BMV < 1) begin : g_bad
      $error("vac_stage: empty branch metric vector");
   end
endmodule

// File: rtl/vac_norm.sv
module vac_norm #(
   parameter int MW      = 12,
   parameter int NST     = 16,
   parameter int SD      = 4,
   parameter bit NORM_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              v_i,
   input  logic [NST*MW-1:0] met_i,
   input  logic [NST*SD-1:0] seg_i,
   output logic              v_o,
   output logic [NST*MW-1:0] met_o,
   output logic [NST*SD-1:0] seg_o
);
   localparam logic [MW-1:0] OFS = MW'(1) << (MW-2);

   logic [NST*MW-1:0] met_n;

   if (NORM_EN) begin : g_norm
      logic hi;
      assign hi = met_i[MW-1];
      for (genvar d = 0; d < NST; d++) begin : g_sub
         assign met_n[d*MW +: MW] = met_i[d*MW +: MW] - (hi ? OFS : '0);
      end
   end else begin : g_pass
      assign met_n = met_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_o   <= 1'b0;
         met_o <= '0;
         seg_o <= '0;
      end else begin
         v_o   <= v_i;
         met_o <= met_n;
         seg_o <= seg_i;
      end
   end
endmodule

// File: rtl/vit_acs_cascade.sv
module vit_acs_cascade #(
   parameter int MW      = 12,
   parameter int BW      = 6,
   parameter int MAX_STG = 4,
   parameter bit NORM_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          in_vld,
   input  logic [((MAX_STG>2)?2:1)-1:0]  cfg_steps,
   input  logic [(1<<MAX_STG)*MW-1:0]    in_metric,
   input  logic [MAX_STG*(1<<MAX_STG)*2*BW-1:0] in_bm,
   output logic                          res_vld,
   output logic [(1<<MAX_STG)*MW-1:0]    res_metric,
   output logic [(1<<MAX_STG)*MAX_STG-1:0] res_seg
);
   localparam int NST = 1 << MAX_STG;
   localparam int SCW = (MAX_STG > 2) ? 2 : 1;
   localparam int BMV = MAX_STG*NST*2*BW;
   localparam int LAT = MAX_STG + 1;

   if (MAX_STG != 2 && MAX_STG != 4) begin : g_chk_stg
      $error("vit_acs_cascade: MAX_STG must be 2 or 4");
   end
   if (BW >= MW - 2) begin : g_chk_w
      $error("vit_acs_cascade: BW must be smaller than MW-2");
   end

   logic                v_p   [MAX_STG+1];
   logic [SCW-1:0]      c_p   [MAX_STG+1];
   logic [NST*MW-1:0]   m_p   [MAX_STG+1];
   logic [NST*MAX_STG-1:0] s_p [MAX_STG+1];
   logic [BMV-1:0]      b_p   [MAX_STG+1];

   assign v_p[0] = in_vld;
   assign c_p[0] = cfg_steps;
   assign m_p[0] = in_metric;
   assign s_p[0] = '0;
   assign b_p[0] = in_bm;

   for (genvar k = 0; k < MAX_STG; k++) begin : g_stg
      vac_stage #(
         .MW(MW), .BW(BW), .NST(NST), .SD(MAX_STG), .SCW(SCW), .IDX(k)
      ) stg_i (
         .clk   (clk),
         .rst   (rst),
         .v_i   (v_p[k]),
         .code_i(c_p[k]),
         .met_i (m_p[k]),
         .seg_i (s_p[k]),
         .bm_i  (b_p[k]),
         .v_o   (v_p[k+1]),
         .code_o(c_p[k+1]),
         .met_o (m_p[k+1]),
         .seg_o (s_p[k+1]),
         .bm_o  (b_p[k+1])
      );
   end

   vac_norm #(
      .MW(MW), .NST(NST), .SD(MAX_STG), .NORM_EN(NORM_EN)
   ) norm_i (
      .clk  (clk),
      .rst  (rst),
      .v_i  (v_p[MAX_STG]),
      .met_i(m_p[MAX_STG]),
      .seg_i(s_p[MAX_STG]),
      .v_o  (res_vld),
      .met_o(res_metric),
      .seg_o(res_seg)
   );
endmodule

// File: rtl/vac_chk.sv
module vac_chk #(
   parameter int MW  = 12,
   parameter int NST = 16,
   parameter int SD  = 4,
   parameter int SCW = 2,
   parameter int LAT = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              in_vld,
   input logic [SCW-1:0]    cfg_steps,
   input logic              res_vld,
   input logic [NST*MW-1:0] res_metric,
   input logic [NST*SD-1:0] res_seg
);
   localparam logic [MW-1:0] NORM_CEIL = MW'(3) << (MW-2);

   logic [LAT-1:0] v_sh;
   logic [SCW-1:0] c_sh [LAT];
   logic           hi_bits;

   always_ff @(posedge clk) begin
      if (rst) begin
         v_sh <= '0;
         for (int i = 0; i < LAT; i++) c_sh[i] <= '0;
      end else begin
         v_sh    <= {v_sh[LAT-2:0], in_vld};
         c_sh[0] <= cfg_steps;
         for (int i = 1; i < LAT; i++) c_sh[i] <= c_sh[i-1];
      end
   end

   always_comb begin
      hi_bits = 1'b0;
      for (int d = 0; d < NST; d++) begin
         if ((res_seg[d*SD +: SD] >> (int'(c_sh[LAT-1]) + 1)) != '0) hi_bits = 1'b1;
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!res_vld && res_seg == '0));

   assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
      res_vld == v_sh[LAT-1]);

   assert_seg_len_R7: assert property (@(posedge clk) disable iff (rst)
      res_vld |-> !hi_bits);

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
      res_vld |-> (res_metric[MW-1:0] < NORM_CEIL));
endmodule

bind vit_acs_cascade vac_chk #(
   .MW(MW), .NST(NST), .SD(MAX_STG), .SCW(SCW), .LAT(LAT)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .in_vld    (in_vld),
   .cfg_steps (cfg_steps),
   .res_vld   (res_vld),
   .res_metric(res_metric),
   .res_seg   (res_seg)
);

// File: tb/vit_acs_cascade_tb_top.sv
module vit_acs_cascade_tb_top;
   localparam int MW  = 12;
   localparam int BW  = 6;
   localparam int SD  = 4;
   localparam int NST = 16;
   localparam int SCW = 2;
   localparam int BMV = SD*NST*2*BW;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_vld = 1'b0;
   logic [SCW-1:0] cfg_steps = '0;
   logic [NST*MW-1:0] in_metric = '0;
   logic [BMV-1:0] in_bm = '0;
   logic res_vld;
   logic [NST*MW-1:0] res_metric;
   logic [NST*SD-1:0] res_seg;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [NST*MW-1:0] exp_m [16];
   logic [NST*SD-1:0] exp_s [16];
   string             exp_t [16];
   int wr = 0;
   int rd = 0;

   always #2 clk = ~clk;

   vit_acs_cascade #(.MW(MW), .BW(BW), .MAX_STG(SD)) dut_i (
      .clk(clk), .rst(rst), .in_vld(in_vld), .cfg_steps(cfg_steps),
      .in_metric(in_metric), .in_bm(in_bm),
      .res_vld(res_vld), .res_metric(res_metric), .res_seg(res_seg)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [NST*MW-1:0] act, input logic [NST*MW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // expected results derived from the requirements
   task automatic model(input logic [NST*MW-1:0] mi, input logic [BMV-1:0] bm, input int code,
                        output logic [NST*MW-1:0] mo, output logic [NST*SD-1:0] so);
      logic [MW-1:0] m [NST];
      logic [MW-1:0] nm [NST];
      logic [SD-1:0] s [NST];
      logic [SD-1:0] ns [NST];
      for (int d = 0; d < NST; d++) begin
         m[d] = mi[d*MW +: MW];
         s[d] = '0;
      end
      for (int k = 0; k <= code; k++) begin
         for (int d = 0; d < NST; d++) begin
            int p;
            logic [MW-1:0] c0, c1;
            p  = (2*d) % NST;
            c0 = m[p]   + MW'(bm[((k*NST+d)*2+0)*BW +: BW]);
            c1 = m[p+1] + MW'(bm[((k*NST+d)*2+1)*BW +: BW]);
            if (c1 > c0) begin
               nm[d] = c1; ns[d] = {s[p+1][SD-2:0], 1'b1};
            end else begin
               nm[d] = c0; ns[d] = {s[p][SD-2:0], 1'b0};
            end
         end
         for (int d = 0; d < NST; d++) begin
            m[d] = nm[d]; s[d] = ns[d];
         end
      end
      if (m[0] >= MW'(1 << (MW-1)))
         for (int d = 0; d < NST; d++) m[d] = m[d] - MW'(1 << (MW-2));
      for (int d = 0; d < NST; d++) begin
         mo[d*MW +: MW] = m[d];
         so[d*SD +: SD] = s[d];
      end
   endtask

   task automatic send(input logic [NST*MW-1:0] mi, input logic [BMV-1:0] bm,
                       input int code, input string tag);
      logic [NST*MW-1:0] mo;
      logic [NST*SD-1:0] so;
      @(negedge clk);
      in_vld    = 1'b1;
      cfg_steps = SCW'(code);
      in_metric = mi;
      in_bm     = bm;
      model(mi, bm, code, mo, so);
      exp_m[wr % 16] = mo;
      exp_s[wr % 16] = so;
      exp_t[wr % 16] = tag;
      wr++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
   endtask

   function automatic logic [NST*MW-1:0] flat_m(input int v);
      logic [NST*MW-1:0] r;
      for (int d = 0; d < NST; d++) r[d*MW +: MW] = MW'(v);
      return r;
   endfunction

   function automatic logic [BMV-1:0] rnd_bm();
      logic [BMV-1:0] r;
      for (int i = 0; i < BMV/32; i++) r[i*32 +: 32] = $urandom;
      return r;
   endfunction

   function automatic logic [NST*MW-1:0] rnd_m();
      logic [NST*MW-1:0] r;
      for (int d = 0; d < NST; d++) r[d*MW +: MW] = MW'($urandom % (1 << (MW-1)));
      return r;
   endfunction

   // output monitor
   always @(negedge clk) begin
      if (!rst && res_vld) begin
         if (rd == wr) begin
            chk(1'b0, "R2", "unexpected result", '0, '0);
         end else begin
            chk(res_metric == exp_m[rd % 16], exp_t[rd % 16], "metrics", res_metric, exp_m[rd % 16]);
            chk(res_seg == exp_s[rd % 16], exp_t[rd % 16], "segments",
                NST*MW'(res_seg), NST*MW'(exp_s[rd % 16]));
            rd++;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "R2", "watchdog expired", '0, '0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [BMV-1:0] bm_a;
      logic [NST*MW-1:0] m_a;
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      chk(res_vld == 1'b0, "R1", "valid after reset", NST*MW'(res_vld), '0);
      chk(res_metric == '0, "R1", "metrics after reset", res_metric, '0);
      chk(res_seg == '0, "R1", "segments after reset", NST*MW'(res_seg), '0);

      // R2: exact latency of a lone pass
      send(rnd_m(), rnd_bm(), 3, "R2");
      for (int i = 1; i <= 5; i++) begin
         @(negedge clk);
         in_vld = 1'b0;
         chk(res_vld == (i == 5), "R2", "latency", NST*MW'(res_vld), NST*MW'(i == 5));
      end
      idle(2);

      // R4: equal candidates everywhere pick branch 0
      send(flat_m(100), '0, 3, "R4");
      idle(6);

      // R5/R7: branch 1 always wins, every step count
      bm_a = '0;
      for (int k = 0; k < SD; k++)
         for (int d = 0; d < NST; d++) bm_a[((k*NST+d)*2+1)*BW +: BW] = BW'(5);
      for (int c = 0; c < SD; c++) send(flat_m(100), bm_a, c, "R5/R7");
      idle(6);

      // R6: late-step branch metrics do not matter with code 1
      m_a  = rnd_m();
      bm_a = rnd_bm();
      send(m_a, bm_a, 1, "R6");
      bm_a[BMV-1 : 2*NST*2*BW] = ~bm_a[BMV-1 : 2*NST*2*BW];
      send(m_a, bm_a, 1, "R6");
      for (int c = 0; c < SD; c++) send(rnd_m(), rnd_bm(), c, "R6/R7");
      idle(6);

      // R8: normalization threshold on both sides and near the top
      send(flat_m((1 << (MW-1)) - 1), '0, 0, "R8");
      send(flat_m(1 << (MW-1)), '0, 0, "R8");
      send(flat_m((1 << (MW-1)) - 1), {BMV{1'b1}}, 3, "R8");
      idle(6);

      // R9: back-to-back burst
      for (int i = 0; i < 8; i++) send(rnd_m(), rnd_bm(), int'($urandom % 4), "R9");
      idle(6);

      // R3: random passes with random gaps
      for (int i = 0; i < 200; i++) begin
         send(rnd_m(), rnd_bm(), int'($urandom % 4), "R3");
         if (($urandom % 3) == 0) idle(1 + int'($urandom % 2));
      end
      idle(10);
      chk(rd == wr, "R2", "all passes returned", NST*MW'(rd), NST*MW'(wr));

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule